// File: doc/BRIEF.md
# Serial Port Compander Stage

This stage sits in the parallel datapath of a synchronous serial port, on both sides of the shift logic. On the transmit side it takes the 16-bit two's-complement word held for transmission and, when companding is turned on for that direction, reduces it to an 8-bit logarithmic code word. The code word is loaded into the transmit shift register in the same transfer cycle that would otherwise carry the raw word. On the receive side it takes the word assembled by the shifter and, when companding is turned on, expands the 8-bit code in its low byte back into a 16-bit two's-complement sample. That sample is written to the receive data register in the same transfer cycle.

Each direction has its own enable and its own law select, which picks either the mu-law or the A-law curve. Samples beyond the selected law's dynamic range are clamped before encoding. While a direction is companding, the word-length fields it passes on to the shift logic are forced to the 8-bit code, so both frame phases shift 8-bit words. When a direction is not companding, words and word-length fields pass through untouched. Serial shifting, frame sync, bit clocks and DMA live elsewhere. Words are exchanged only through the two load strobes.

Top module: `sport_compander`

## Requirements
- R1: With tx_comp_en low, a cycle with tx_load high copies tx_hold unchanged into tx_shift_word at that clock edge. tx_shift_word keeps its value in every cycle where tx_load is low.
- R2: With tx_comp_en high and tx_law_sel 0 (mu-law), the load writes a code into tx_shift_word[7:0] and zeroes bits 15:8. The code is built as follows. Add 33 to the magnitude. The segment (0..7) is the position of the highest set bit of the biased value minus 5. The mantissa is the 4 bits just below that highest bit. If the biased value reaches 8192, segment 7 and mantissa 15 are used. The byte {0, segment, mantissa} is XORed with 0xFF for non-negative samples and with 0x7F for negative ones. So 0 gives 0xFF and -1 gives 0x7E.
- R3: With tx_comp_en high and tx_law_sel 1 (A-law), the magnitude is the sample itself when non-negative, or -sample-1 when negative. The segment is 0 below 32; otherwise it is the position of the highest set bit minus 4. The mantissa is magnitude bits 4:1 for segments 0 and 1, and the magnitude shifted right by the segment for the others. The byte {0, segment, mantissa} is XORed with 0xD5 for non-negative samples and with 0x55 for negative ones. So 0 gives 0xD5 and -1 gives 0x55.
- R4: Under mu-law, samples are first clamped to -8192..8191. Every sample of 8191 or more encodes to 0x80, and every sample of -8192 or less encodes to 0x00.
- R5: Under A-law, samples are first clamped to -4096..4095. Every sample of 4095 or more encodes to 0xAA, and every sample of -4096 or less encodes to 0x2A.
- R6: With rx_comp_en low, a cycle with rx_xfer high copies rx_buf unchanged into rx_data. rx_data keeps its value in every cycle where rx_xfer is low.
- R7: With rx_comp_en high and rx_law_sel 0, the code c = rx_buf[7:0] is inverted to u. The segment is u[6:4] and the mantissa u[3:0]. The magnitude is ((2*mantissa+33) shifted left by segment) - 33, negated when u[7] is 1 and sign-extended to 16 bits. So 0xFF gives 0, 0x80 gives +8031 and 0x00 gives -8031.
- R8: With rx_comp_en high and rx_law_sel 1, the code is XORed with 0x55 to give a. The magnitude is 2*mantissa+1 for segment 0, and 2*mantissa+33 for segment 1. For segment s of 2 or more it is (2*mantissa+33) shifted left by s-1. The result is positive when a[7] is 1 and negated otherwise. So 0xD5 gives +1, 0x55 gives -1 and 0xAA gives +4032.
- R9: While rx_comp_en is high, rx_buf[15:8] has no effect on rx_data.
- R10: Each word-length field is 3 bits, and the value 0 selects an 8-bit word. Both phase fields of tx_wlen_eff are 0 while tx_comp_en is high, and both equal tx_wlen_cfg while it is low. The same rule links rx_wlen_eff, rx_comp_en and rx_wlen_cfg.
- R11: The enable and law select of one direction have no effect on the other direction's result.
- R12: While rst_n is low, tx_shift_word and rx_data read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_comp_en | input | 1 | Transmit companding enable |
| tx_law_sel | input | 1 | Transmit law: 0 mu-law, 1 A-law |
| tx_wlen_cfg | input | 6 | Configured transmit word length, phase 1 in bits 2:0, phase 2 in bits 5:3 |
| tx_wlen_eff | output | 6 | Word length passed to the transmit shifter |
| tx_hold | input | 16 | Transmit holding word |
| tx_load | input | 1 | Transfer strobe from holding register to shift register |
| tx_shift_word | output | 16 | Word loaded into the transmit shift register |
| rx_comp_en | input | 1 | Receive companding enable |
| rx_law_sel | input | 1 | Receive law: 0 mu-law, 1 A-law |
| rx_wlen_cfg | input | 6 | Configured receive word length, same layout as transmit |
| rx_wlen_eff | output | 6 | Word length passed to the receive shifter |
| rx_buf | input | 16 | Receive buffer word from the shifter |
| rx_xfer | input | 1 | Transfer strobe from buffer register to data register |
| rx_data | output | 16 | Receive data register |

## Verification
The properties take for granted that the enable and law select of a direction are steady in the cycle of that direction's strobe. They also take for granted that no strobe is raised until the internally synchronised reset has released. The value checks compare the loaded word with that cycle's holding word, and the range checks assume the law sampled with the strobe is the one applied. The stimulus drives every input on the falling edge, and changes a law or an enable only together with a new strobe. After releasing reset it waits several cycles before the first transfer.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  localparam int CODE_W      = 8;
  localparam int SEG_W       = 3;
  localparam int MANT_W      = 4;
  localparam int MU_RANGE_W  = 14;
  localparam int A_RANGE_W   = 13;
  localparam int MU_BIAS     = 33;
  localparam int A_SEG1_OFS  = 33;
  localparam int MU_SEG_BASE = 5;   // highest-bit index minus this gives the segment
  localparam int A_SEG_BASE  = 4;
  localparam int NUM_SEG     = 8;

  localparam logic [CODE_W-1:0] MU_MASK_POS = 8'hFF;
  localparam logic [CODE_W-1:0] MU_MASK_NEG = 8'h7F;
  localparam logic [CODE_W-1:0] A_MASK_POS  = 8'hD5;
  localparam logic [CODE_W-1:0] A_MASK_NEG  = 8'h55;
  localparam logic [CODE_W-1:0] BODY_TOP    = 8'h7F;
endpackage

// File: rtl/cmp_saturate.sv
module cmp_saturate #(
  parameter int IN_W    = 16,
  parameter int RANGE_W = 14
) (
  input  logic [IN_W-1:0] din,
  output logic [IN_W-1:0] dout
);
  generate
    if (RANGE_W >= IN_W) begin : g_pass
      assign dout = din;
    end else begin : g_clamp
      localparam logic signed [IN_W-1:0] HI = (IN_W'(1) << (RANGE_W - 1)) - IN_W'(1);
      localparam logic signed [IN_W-1:0] LO = ~HI;
      logic signed [IN_W-1:0] s;
      assign s = $signed(din);
      always_comb begin
        if (s > HI)      dout = HI;
        else if (s < LO) dout = LO;
        else             dout = din;
      end
    end
  endgenerate
endmodule

// File: rtl/cmp_encoder.sv
module cmp_encoder
  import cmp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  law_e                law_i,
  output logic [CODE_W-1:0]   code_o
);
  localparam int MU_TOP_BIT = MU_SEG_BASE + NUM_SEG - 1;
  localparam int A_TOP_BIT  = A_SEG_BASE + NUM_SEG - 1;

  logic [SAMPLE_W-1:0] mu_sat, a_sat;

  cmp_saturate #(.IN_W(SAMPLE_W), .RANGE_W(MU_RANGE_W)) u_mu_sat (.din(sample_i), .dout(mu_sat));
  cmp_saturate #(.IN_W(SAMPLE_W), .RANGE_W(A_RANGE_W))  u_a_sat  (.din(sample_i), .dout(a_sat));

  // mu-law path
  logic                mu_neg, mu_ovf;
  logic [SAMPLE_W-1:0] mu_mag, mu_biased;
  logic [SEG_W-1:0]    mu_seg;
  logic [MANT_W-1:0]   mu_mant;
  logic [CODE_W-1:0]   mu_body, mu_code;

  always_comb begin
    mu_neg    = mu_sat[SAMPLE_W-1];
    mu_mag    = mu_neg ? (~mu_sat + SAMPLE_W'(1)) : mu_sat;
    mu_biased = mu_mag + SAMPLE_W'(MU_BIAS);
    mu_ovf    = |mu_biased[SAMPLE_W-1:MU_TOP_BIT+1];
    mu_seg    = '0;
    for (int b = MU_SEG_BASE + 1; b <= MU_TOP_BIT; b++) begin
      if (mu_biased[b]) mu_seg = SEG_W'(b - MU_SEG_BASE);
    end
    mu_mant = MANT_W'(mu_biased >> (32'(mu_seg) + 1));
    mu_body = mu_ovf ? BODY_TOP : {1'b0, mu_seg, mu_mant};
    mu_code = mu_body ^ (mu_neg ? MU_MASK_NEG : MU_MASK_POS);
  end

  // A-law path
  logic                a_neg;
  logic [SAMPLE_W-1:0] a_mag;
  logic [SEG_W-1:0]    a_seg;
  logic [MANT_W-1:0]   a_mant;
  logic [CODE_W-1:0]   a_code;

  always_comb begin
    a_neg = a_sat[SAMPLE_W-1];
    a_mag = a_neg ? ~a_sat : a_sat;
    a_seg = '0;
    for (int b = A_SEG_BASE + 1; b <= A_TOP_BIT; b++) begin
      if (a_mag[b]) a_seg = SEG_W'(b - A_SEG_BASE);
    end
    a_mant = (a_seg < SEG_W'(2)) ? a_mag[MANT_W:1] : MANT_W'(a_mag >> a_seg);
    a_code = {1'b0, a_seg, a_mant} ^ (a_neg ? A_MASK_NEG : A_MASK_POS);
  end

  assign code_o = (law_i == LAW_A) ? a_code : mu_code;
endmodule

// File: rtl/cmp_decoder.sv
module cmp_decoder
  import cmp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [CODE_W-1:0]   code_i,
  input  law_e                law_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  logic [CODE_W-1:0]   mu_u, a_x;
  logic [SAMPLE_W-1:0] mu_base, mu_mag, mu_sample;
  logic [SAMPLE_W-1:0] a_base, a_mag, a_sample;
  logic [SEG_W-1:0]    a_seg;

  always_comb begin
    mu_u      = ~code_i;
    mu_base   = SAMPLE_W'({mu_u[MANT_W-1:0], 1'b0}) + SAMPLE_W'(MU_BIAS);
    mu_mag    = (mu_base << mu_u[CODE_W-2 -: SEG_W]) - SAMPLE_W'(MU_BIAS);
    mu_sample = mu_u[CODE_W-1] ? (~mu_mag + SAMPLE_W'(1)) : mu_mag;
  end

  always_comb begin
    a_x    = code_i ^ A_MASK_NEG;
    a_seg  = a_x[CODE_W-2 -: SEG_W];
    if (a_seg == '0) a_base = SAMPLE_W'({a_x[MANT_W-1:0], 1'b1});
    else             a_base = SAMPLE_W'({a_x[MANT_W-1:0], 1'b0}) + SAMPLE_W'(A_SEG1_OFS);
    a_mag    = (a_seg > SEG_W'(1)) ? (a_base << (a_seg - SEG_W'(1))) : a_base;
    a_sample = a_x[CODE_W-1] ? a_mag : (~a_mag + SAMPLE_W'(1));
  end

  assign sample_o = (law_i == LAW_A) ? a_sample : mu_sample;
endmodule

// File: rtl/cmp_wlen_ovr.sv
module cmp_wlen_ovr #(
  parameter int PHASES = 2,
  parameter int WLEN_W = 3
) (
  input  logic                     comp_en,
  input  logic [PHASES*WLEN_W-1:0] wlen_cfg,
  output logic [PHASES*WLEN_W-1:0] wlen_eff
);
  localparam logic [WLEN_W-1:0] WLEN_8BIT = '0;

  generate
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
      assign wlen_eff[p*WLEN_W +: WLEN_W] = comp_en ? WLEN_8BIT : wlen_cfg[p*WLEN_W +: WLEN_W];
    end
  endgenerate
endmodule

// File: rtl/sport_compander.sv
module sport_compander
  import cmp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PHASES   = 2,
  parameter int WLEN_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_comp_en,
  input  logic                     tx_law_sel,
  input  logic [PHASES*WLEN_W-1:0] tx_wlen_cfg,
  output logic [PHASES*WLEN_W-1:0] tx_wlen_eff,
  input  logic [SAMPLE_W-1:0]      tx_hold,
  input  logic                     tx_load,
  output logic [SAMPLE_W-1:0]      tx_shift_word,
  input  logic                     rx_comp_en,
  input  logic                     rx_law_sel,
  input  logic [PHASES*WLEN_W-1:0] rx_wlen_cfg,
  output logic [PHASES*WLEN_W-1:0] rx_wlen_eff,
  input  logic [SAMPLE_W-1:0]      rx_buf,
  input  logic                     rx_xfer,
  output logic [SAMPLE_W-1:0]      rx_data
);
  localparam int PAD_W = SAMPLE_W - CODE_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [CODE_W-1:0]   tx_code;
  logic [SAMPLE_W-1:0] rx_expanded;
  logic [SAMPLE_W-1:0] tx_next, rx_next;
  logic [SAMPLE_W-1:0] tx_shift_q, rx_data_q;

  cmp_encoder #(.SAMPLE_W(SAMPLE_W)) u_enc (
    .sample_i (tx_hold),
    .law_i    (law_e'(tx_law_sel)),
    .code_o   (tx_code)
  );

  cmp_decoder #(.SAMPLE_W(SAMPLE_W)) u_dec (
    .code_i   (rx_buf[CODE_W-1:0]),
    .law_i    (law_e'(rx_law_sel)),
    .sample_o (rx_expanded)
  );

  cmp_wlen_ovr #(.PHASES(PHASES), .WLEN_W(WLEN_W)) u_tx_wlen (
    .comp_en  (tx_comp_en),
    .wlen_cfg (tx_wlen_cfg),
    .wlen_eff (tx_wlen_eff)
  );

  cmp_wlen_ovr #(.PHASES(PHASES), .WLEN_W(WLEN_W)) u_rx_wlen (
    .comp_en  (rx_comp_en),
    .wlen_cfg (rx_wlen_cfg),
    .wlen_eff (rx_wlen_eff)
  );

  // next-state
  always_comb begin
    tx_next = tx_comp_en ? {{PAD_W{1'b0}}, tx_code} : tx_hold;
    rx_next = rx_comp_en ? rx_expanded : rx_buf;
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     tx_shift_q <= '0;
    else if (tx_load) tx_shift_q <= tx_next;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     rx_data_q <= '0;
    else if (rx_xfer) rx_data_q <= rx_next;
  end

  assign tx_shift_word = tx_shift_q;
  assign rx_data       = rx_data_q;
endmodule

// File: rtl/sport_compander_chk.sv
module sport_compander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_comp_en,
  input logic        tx_law_sel,
  input logic [5:0]  tx_wlen_eff,
  input logic [15:0] tx_hold,
  input logic        tx_load,
  input logic [15:0] tx_shift_word,
  input logic        rx_comp_en,
  input logic        rx_law_sel,
  input logic [5:0]  rx_wlen_eff,
  input logic [15:0] rx_buf,
  input logic        rx_xfer,
  input logic [15:0] rx_data
);
  a_r1_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_load |=> $stable(tx_shift_word));

  a_r1_tx_pass: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && !tx_comp_en |=> tx_shift_word == $past(tx_hold));

  a_r2_code_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_comp_en |=> tx_shift_word[15:8] == 8'h00);

  a_r4_mu_top: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_comp_en && !tx_law_sel && ($signed(tx_hold) > 16'sd8191)
    |=> tx_shift_word == 16'h0080);

  a_r5_a_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_comp_en && tx_law_sel && ($signed(tx_hold) < -16'sd4096)
    |=> tx_shift_word == 16'h002A);

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_xfer |=> $stable(rx_data));

  a_r6_rx_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer && !rx_comp_en |=> rx_data == $past(rx_buf));

  a_r7_mu_span: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer && rx_comp_en && !rx_law_sel
    |=> ($signed(rx_data) <= 16'sd8031) && ($signed(rx_data) >= -16'sd8031));

  a_r8_a_span: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer && rx_comp_en && rx_law_sel
    |=> ($signed(rx_data) <= 16'sd4032) && ($signed(rx_data) >= -16'sd4032));

  a_r10_tx_wlen: assert property (@(posedge clk) disable iff (!rst_n)
    tx_comp_en |-> tx_wlen_eff == 6'd0);

  a_r10_rx_wlen: assert property (@(posedge clk) disable iff (!rst_n)
    rx_comp_en |-> rx_wlen_eff == 6'd0);
endmodule

bind sport_compander sport_compander_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .tx_comp_en    (tx_comp_en),
  .tx_law_sel    (tx_law_sel),
  .tx_wlen_eff   (tx_wlen_eff),
  .tx_hold       (tx_hold),
  .tx_load       (tx_load),
  .tx_shift_word (tx_shift_word),
  .rx_comp_en    (rx_comp_en),
  .rx_law_sel    (rx_law_sel),
  .rx_wlen_eff   (rx_wlen_eff),
  .rx_buf        (rx_buf),
  .rx_xfer       (rx_xfer),
  .rx_data       (rx_data)
);

// File: tb/sim_sport_compander.sv
module sim_sport_compander;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk;
  logic        rst_n;
  logic        tx_comp_en, tx_law_sel, tx_load;
  logic [5:0]  tx_wlen_cfg, tx_wlen_eff;
  logic [15:0] tx_hold, tx_shift_word;
  logic        rx_comp_en, rx_law_sel, rx_xfer;
  logic [5:0]  rx_wlen_cfg, rx_wlen_eff;
  logic [15:0] rx_buf, rx_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  sport_compander u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_comp_en(tx_comp_en), .tx_law_sel(tx_law_sel),
    .tx_wlen_cfg(tx_wlen_cfg), .tx_wlen_eff(tx_wlen_eff),
    .tx_hold(tx_hold), .tx_load(tx_load), .tx_shift_word(tx_shift_word),
    .rx_comp_en(rx_comp_en), .rx_law_sel(rx_law_sel),
    .rx_wlen_cfg(rx_wlen_cfg), .rx_wlen_eff(rx_wlen_eff),
    .rx_buf(rx_buf), .rx_xfer(rx_xfer), .rx_data(rx_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model, written from the requirements ----------------
  function automatic logic [7:0] ref_mu_enc(int s);
    int v, m, seg;
    bit neg;
    logic [7:0] body;
    v = (s > 8191) ? 8191 : ((s < -8192) ? -8192 : s);
    neg = (v < 0);
    m = neg ? -v : v;
    if (m > 8159) m = 8159;
    m = m + 33;
    seg = 0;
    for (int i = 0; i < 8; i++) if (m > ((64 << i) - 1)) seg = i + 1;
    if (seg >= 8) body = 8'h7F;
    else body = 8'((seg << 4) | ((m >> (seg + 1)) & 15));
    return neg ? (body ^ 8'h7F) : (body ^ 8'hFF);
  endfunction

  function automatic logic [7:0] ref_a_enc(int s);
    int v, m, seg;
    logic [7:0] mask, body;
    v = (s > 4095) ? 4095 : ((s < -4096) ? -4096 : s);
    if (v >= 0) begin m = v; mask = 8'hD5; end
    else begin m = -v - 1; mask = 8'h55; end
    seg = 0;
    for (int i = 0; i < 8; i++) if (m > ((32 << i) - 1)) seg = i + 1;
    if (seg >= 8) body = 8'h7F;
    else if (seg < 2) body = 8'((seg << 4) | ((m >> 1) & 15));
    else body = 8'((seg << 4) | ((m >> seg) & 15));
    return body ^ mask;
  endfunction

  function automatic logic [15:0] ref_mu_dec(logic [7:0] c);
    int u, t, r;
    u = int'(~c);
    t = (((u & 15) << 3) + 132) << ((u >> 4) & 7);
    r = ((u & 128) != 0) ? (132 - t) : (t - 132);
    return 16'(r / 4);
  endfunction

  function automatic logic [15:0] ref_a_dec(logic [7:0] c);
    int a, t, seg, r;
    a = int'(c ^ 8'h55);
    t = (a & 15) << 4;
    seg = (a >> 4) & 7;
    t = t + ((seg == 0) ? 8 : 264);
    if (seg > 1) t = t << (seg - 1);
    r = ((a & 128) != 0) ? t : -t;
    return 16'(r / 8);
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tx_xfer(int s, logic en, logic law);
    @(negedge clk);
    tx_hold = 16'(s); tx_comp_en = en; tx_law_sel = law; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic rx_move(logic [15:0] w, logic en, logic law);
    @(negedge clk);
    rx_buf = w; rx_comp_en = en; rx_law_sel = law; rx_xfer = 1'b1;
    @(negedge clk);
    rx_xfer = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    rst_n = 1'b0;
    tx_comp_en = 0; tx_law_sel = 0; tx_load = 0; tx_hold = 16'h1234; tx_wlen_cfg = 6'b010_001;
    rx_comp_en = 0; rx_law_sel = 0; rx_xfer = 0; rx_buf = 16'h4321; rx_wlen_cfg = 6'b100_011;
    repeat (3) @(negedge clk);
    chk("R12", "tx_shift_word in reset", tx_shift_word, 16'h0000);
    chk("R12", "rx_data in reset", rx_data, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "tx_shift_word after release", tx_shift_word, 16'h0000);
  endtask

  task automatic t_tx_pass;
    tx_xfer(16'hBEEF, 1'b0, 1'b0);
    chk("R1", "raw load", tx_shift_word, 16'hBEEF);
    tx_xfer(-30000, 1'b0, 1'b1);
    chk("R1", "raw load, law ignored", tx_shift_word, 16'(-30000));
    tx_hold = 16'h0F0F;
    repeat (3) @(negedge clk);
    chk("R1", "hold without strobe", tx_shift_word, 16'(-30000));
  endtask

  task automatic t_tx_mu;
    tx_xfer(0, 1'b1, 1'b0);  chk("R2", "mu 0", tx_shift_word, 16'h00FF);
    tx_xfer(-1, 1'b1, 1'b0); chk("R2", "mu -1", tx_shift_word, 16'h007E);
    for (int s = -9000; s <= 9000; s += 29) begin
      tx_xfer(s, 1'b1, 1'b0);
      chk("R2", $sformatf("mu sweep %0d", s), tx_shift_word, {8'h00, ref_mu_enc(s)});
    end
  endtask

  task automatic t_tx_a;
    tx_xfer(0, 1'b1, 1'b1);  chk("R3", "A 0", tx_shift_word, 16'h00D5);
    tx_xfer(-1, 1'b1, 1'b1); chk("R3", "A -1", tx_shift_word, 16'h0055);
    for (int s = -4700; s <= 4700; s += 13) begin
      tx_xfer(s, 1'b1, 1'b1);
      chk("R3", $sformatf("A sweep %0d", s), tx_shift_word, {8'h00, ref_a_enc(s)});
    end
  endtask

  task automatic t_sat;
    tx_xfer(8191, 1'b1, 1'b0);   chk("R4", "mu 8191", tx_shift_word, 16'h0080);
    tx_xfer(32767, 1'b1, 1'b0);  chk("R4", "mu 32767", tx_shift_word, 16'h0080);
    tx_xfer(-8192, 1'b1, 1'b0);  chk("R4", "mu -8192", tx_shift_word, 16'h0000);
    tx_xfer(-32768, 1'b1, 1'b0); chk("R4", "mu -32768", tx_shift_word, 16'h0000);
    tx_xfer(4095, 1'b1, 1'b1);   chk("R5", "A 4095", tx_shift_word, 16'h00AA);
    tx_xfer(20000, 1'b1, 1'b1);  chk("R5", "A 20000", tx_shift_word, 16'h00AA);
    tx_xfer(-4096, 1'b1, 1'b1);  chk("R5", "A -4096", tx_shift_word, 16'h002A);
    tx_xfer(-32768, 1'b1, 1'b1); chk("R5", "A -32768", tx_shift_word, 16'h002A);
  endtask

  task automatic t_rx_pass;
    rx_move(16'hC0DE, 1'b0, 1'b1);
    chk("R6", "raw transfer", rx_data, 16'hC0DE);
    rx_buf = 16'h5A5A;
    repeat (3) @(negedge clk);
    chk("R6", "hold without strobe", rx_data, 16'hC0DE);
  endtask

  task automatic t_rx_mu;
    rx_move(16'h00FF, 1'b1, 1'b0); chk("R7", "mu 0xFF", rx_data, 16'd0);
    rx_move(16'h0080, 1'b1, 1'b0); chk("R7", "mu 0x80", rx_data, 16'd8031);
    rx_move(16'h0000, 1'b1, 1'b0); chk("R7", "mu 0x00", rx_data, 16'(-8031));
    for (int c = 0; c < 256; c++) begin
      rx_move(16'(c), 1'b1, 1'b0);
      chk("R7", $sformatf("mu code %0h", c), rx_data, ref_mu_dec(8'(c)));
    end
  endtask

  task automatic t_rx_a;
    rx_move(16'h00D5, 1'b1, 1'b1); chk("R8", "A 0xD5", rx_data, 16'd1);
    rx_move(16'h0055, 1'b1, 1'b1); chk("R8", "A 0x55", rx_data, 16'(-1));
    rx_move(16'h00AA, 1'b1, 1'b1); chk("R8", "A 0xAA", rx_data, 16'd4032);
    for (int c = 0; c < 256; c++) begin
      rx_move(16'(c), 1'b1, 1'b1);
      chk("R8", $sformatf("A code %0h", c), rx_data, ref_a_dec(8'(c)));
    end
  endtask

  task automatic t_rx_upper;
    rx_move(16'hA580, 1'b1, 1'b0); chk("R9", "mu upper byte", rx_data, 16'd8031);
    rx_move(16'hFFD5, 1'b1, 1'b1); chk("R9", "A upper byte", rx_data, 16'd1);
    rx_move(16'h3C37, 1'b1, 1'b1); chk("R9", "A upper byte 2", rx_data, ref_a_dec(8'h37));
  endtask

  task automatic t_wlen;
    @(negedge clk);
    tx_wlen_cfg = 6'b101_011; rx_wlen_cfg = 6'b110_100;
    tx_comp_en = 1'b0; rx_comp_en = 1'b0;
    #1;
    chk("R10", "tx wlen pass", {10'd0, tx_wlen_eff}, {10'd0, 6'b101_011});
    chk("R10", "rx wlen pass", {10'd0, rx_wlen_eff}, {10'd0, 6'b110_100});
    @(negedge clk);
    tx_comp_en = 1'b1;
    #1;
    chk("R10", "tx wlen forced", {10'd0, tx_wlen_eff}, 16'd0);
    chk("R11", "rx wlen untouched by tx enable", {10'd0, rx_wlen_eff}, {10'd0, 6'b110_100});
    @(negedge clk);
    tx_comp_en = 1'b0; rx_comp_en = 1'b1;
    #1;
    chk("R10", "rx wlen forced", {10'd0, rx_wlen_eff}, 16'd0);
    chk("R11", "tx wlen untouched by rx enable", {10'd0, tx_wlen_eff}, {10'd0, 6'b101_011});
  endtask

  task automatic t_indep;
    // both strobes together, opposite settings per direction
    @(negedge clk);
    tx_hold = 16'(-1000); tx_comp_en = 1'b1; tx_law_sel = 1'b0; tx_load = 1'b1;
    rx_buf = 16'h00AA;    rx_comp_en = 1'b1; rx_law_sel = 1'b1; rx_xfer = 1'b1;
    @(negedge clk);
    tx_load = 1'b0; rx_xfer = 1'b0;
    chk("R11", "tx mu with rx A", tx_shift_word, {8'h00, ref_mu_enc(-1000)});
    chk("R11", "rx A with tx mu", rx_data, 16'd4032);
    @(negedge clk);
    tx_hold = 16'd777; tx_comp_en = 1'b0; tx_law_sel = 1'b1; tx_load = 1'b1;
    rx_buf = 16'h0080; rx_comp_en = 1'b1; rx_law_sel = 1'b0; rx_xfer = 1'b1;
    @(negedge clk);
    tx_load = 1'b0; rx_xfer = 1'b0;
    chk("R11", "tx raw with rx mu", tx_shift_word, 16'd777);
    chk("R11", "rx mu with tx raw", rx_data, 16'd8031);
  endtask

  initial begin
    t_reset();
    t_tx_pass();
    t_tx_mu();
    t_tx_a();
    t_sat();
    t_rx_pass();
    t_rx_mu();
    t_rx_a();
    t_rx_upper();
    t_wlen();
    t_indep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule